// File: doc/BRIEF.md
# PS/2 Device-to-Host Frame Receiver

This block turns the clock and data lines of a PS/2 port into received bytes. Both lines are taken on a sample tick, a one-cycle strobe at about 1 MHz derived from the system clock. Each line passes through a two-stage synchroniser clocked by that tick. A falling edge of the port clock makes the receiver capture the data line. The block checks each frame. A good byte goes into a small first-in first-out store. A parity fault, a stop-bit fault or a stalled frame is reported as a one-cycle pulse for a neighbouring status block.

The receiver is a four-state machine with these states:
- **ST_IDLE**: waits for a start bit.
- **ST_DATA**: shifts in eight data bits.
- **ST_PARITY**: captures the parity bit.
- **ST_STOP**: checks the stop bit.

Its transitions are:
- **start**: ST_IDLE to ST_DATA, on a falling edge that samples a low data line.
- **last-data**: ST_DATA to ST_PARITY, on the edge of the eighth data bit.
- **parity**: ST_PARITY to ST_STOP, on the next edge.
- **finish**: ST_STOP to ST_IDLE, on the stop-bit edge.
- **timeout**: any busy state to ST_IDLE, when 100 sample ticks pass with no edge.

The store holds three bytes. Its fill level is reported in two bits. A flush input empties it without touching the frame on the line.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, fill_count is 0, rx_avail is low and all pulse outputs are low.
- R2: A frame is: a low start bit, 8 data bits least significant first, an odd parity bit and a high stop bit. Each bit is taken on a falling edge of the port clock. A good frame puts its byte in the store, and the byte appears on rd_data[7:0] when it reaches the head.
- R3: If the data bits and the parity bit together hold an even number of ones, err_parity pulses for one cycle and the byte is not stored.
- R4: If the stop bit is low, err_stop pulses for one cycle and the byte is not stored.
- R5: After a frame has started, 100 sample ticks with no port clock falling edge make err_timeout pulse once. The receiver then returns to ST_IDLE and drops the partial byte. A frame whose edges are closer together never times out.
- R6: The store is first-in first-out. fill_count (2 bits) gives the number of bytes held, at most 3. A one-cycle rd_en removes the head byte.
- R7: A good byte that arrives while 3 bytes are held is dropped, and rx_overflow pulses for one cycle.
- R8: A one-cycle rx_flush pulse makes fill_count 0 on the next cycle. A frame in progress during the flush is still received and stored.
- R9: rd_en while the store is empty has no effect: fill_count stays 0, and the next good byte reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe at the line sample rate |
| ps2_clk_in | input | 1 | PS/2 clock line level |
| ps2_data_in | input | 1 | PS/2 data line level |
| rx_flush | input | 1 | Empties the receive store |
| rd_en | input | 1 | Removes the head byte |
| rd_data | output | 8 | Head byte of the store |
| fill_count | output | 2 | Number of bytes held |
| rx_avail | output | 1 | Store not empty |
| err_parity | output | 1 | Parity fault pulse |
| err_stop | output | 1 | Stop-bit fault pulse |
| err_timeout | output | 1 | Receive timeout pulse |
| rx_overflow | output | 1 | Byte dropped on a full store |

## Verification
Some behaviours are checked by assertions on every cycle:
- The fill level never goes above three.
- A flush empties the store by the next cycle.
- A push onto a full store raises the overflow pulse.
- A pop on an empty store leaves it empty.
- Each fault pulse lasts one cycle.
- A timeout always leaves the receiver idle.
- The stall counter stays below its limit.

Other behaviours can only be shown by the bench scenarios. These are the bit order and parity sense of real frames, whether faulty frames are kept out of the store, the order in which bytes read back, and recovery after a stalled frame. They also include a flush that lands in the middle of a frame.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2,
        ST_STOP   = 2'd3
    } rx_state_t;
endpackage

// File: rtl/ps2rx_sampler.sv
// Synchronises both lines on the sample tick and reports port-clock falls.
module ps2rx_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic fall_o,
    output logic bit_o
);
    // clock chain is one longer: the extra stage holds the previous synced level
    logic [SYNC_STAGES:0]   clk_ch;
    logic [SYNC_STAGES-1:0] dat_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_ch <= '1;
            dat_ch <= '1;
            fall_o <= 1'b0;
            bit_o  <= 1'b1;
        end else begin
            fall_o <= 1'b0;
            if (tick_i) begin
                clk_ch <= {clk_ch[SYNC_STAGES-1:0], ps2_clk_i};
                dat_ch <= {dat_ch[SYNC_STAGES-2:0], ps2_dat_i};
                fall_o <= clk_ch[SYNC_STAGES] & ~clk_ch[SYNC_STAGES-1];
                bit_o  <= dat_ch[SYNC_STAGES-1];
            end
        end
    end

    a_r2_fall_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(tick_i));
endmodule

// File: rtl/ps2rx_deser.sv
// Frame state machine: start, data, parity, stop, with stall watchdog.
module ps2rx_deser
    import ps2rx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TIMEOUT_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fall_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              err_parity_o,
    output logic              err_stop_o,
    output logic              err_timeout_o
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int TO_W  = $clog2(TIMEOUT_TICKS + 1);

    rx_state_t         state, nxt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic [TO_W-1:0]   wd_cnt;
    logic              timeout_hit;
    logic              good_par;

    assign timeout_hit = (state != ST_IDLE) && tick_i && !fall_i &&
                         (wd_cnt == TO_W'(TIMEOUT_TICKS - 1));
    assign good_par    = ^{shreg, par_bit};
    assign byte_o      = shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (fall_i && !bit_i) nxt = ST_DATA;
            ST_DATA: begin
                if (timeout_hit) nxt = ST_IDLE;
                else if (fall_i && bit_idx == IDX_W'(DATA_W - 1)) nxt = ST_PARITY;
            end
            ST_PARITY: begin
                if (timeout_hit) nxt = ST_IDLE;
                else if (fall_i) nxt = ST_STOP;
            end
            ST_STOP: begin
                if (timeout_hit || fall_i) nxt = ST_IDLE;
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx       <= '0;
            shreg         <= '0;
            par_bit       <= 1'b0;
            wd_cnt        <= '0;
            byte_valid_o  <= 1'b0;
            err_parity_o  <= 1'b0;
            err_stop_o    <= 1'b0;
            err_timeout_o <= 1'b0;
        end else begin
            byte_valid_o  <= 1'b0;
            err_parity_o  <= 1'b0;
            err_stop_o    <= 1'b0;
            err_timeout_o <= 1'b0;

            if (state == ST_IDLE || fall_i || timeout_hit) wd_cnt <= '0;
            else if (tick_i) wd_cnt <= wd_cnt + 1'b1;

            if (timeout_hit) begin
                err_timeout_o <= 1'b1;
            end else if (fall_i) begin
                unique case (state)
                    ST_IDLE:   bit_idx <= '0;
                    ST_DATA: begin
                        shreg   <= {bit_i, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                    ST_PARITY: par_bit <= bit_i;
                    ST_STOP: begin
                        if (good_par && bit_i) byte_valid_o <= 1'b1;
                        else begin
                            err_parity_o <= !good_par;
                            err_stop_o   <= !bit_i;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r5_timeout_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout_o |-> state == ST_IDLE);
    a_r5_wd_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cnt < TO_W'(TIMEOUT_TICKS));
    a_r2_good_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> !err_parity_o && !err_stop_o && !err_timeout_o);
    a_r3_parity_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity_o |=> !err_parity_o);
    a_r4_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_stop_o |=> !err_stop_o);
endmodule

// File: rtl/ps2rx_fifo.sv
// Small receive store with flush and overflow pulse.
module ps2rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic                       pop_i,
    input  logic                       flush_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       empty_o,
    output logic                       overflow_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              room, do_pop, do_push;

    assign do_pop  = pop_i && (count != '0) && !flush_i;
    assign room    = (count < CNT_W'(DEPTH)) || do_pop;
    assign do_push = push_i && !flush_i && room;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PTR_W'(g)) mem[g] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            overflow_o <= 1'b0;
        end else begin
            overflow_o <= push_i && !flush_i && !room;
            if (flush_i) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_push) wr_ptr <= wrap_inc(wr_ptr);
                if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
                if (do_push && !do_pop)      count <= count + 1'b1;
                else if (do_pop && !do_push) count <= count - 1'b1;
            end
        end
    end

    assign rdata_o = mem[rd_ptr];
    assign count_o = count;
    assign empty_o = (count == '0);

    a_r6_count_le_depth: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> count == '0);
    a_r7_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i && !pop_i && count == CNT_W'(DEPTH)) |=> overflow_o);
    a_r9_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count == '0) |=> count == '0);
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
    parameter int DATA_W        = 8,
    parameter int FIFO_DEPTH    = 3,
    parameter int TIMEOUT_TICKS = 100,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sample_tick,
    input  logic                            ps2_clk_in,
    input  logic                            ps2_data_in,
    input  logic                            rx_flush,
    input  logic                            rd_en,
    output logic [DATA_W-1:0]               rd_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fill_count,
    output logic                            rx_avail,
    output logic                            err_parity,
    output logic                            err_stop,
    output logic                            err_timeout,
    output logic                            rx_overflow
);
    logic              fall, sbit, bvalid, empty;
    logic [DATA_W-1:0] rbyte;

    ps2rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .tick_i(sample_tick),
        .ps2_clk_i(ps2_clk_in), .ps2_dat_i(ps2_data_in),
        .fall_o(fall), .bit_o(sbit)
    );

    ps2rx_deser #(.DATA_W(DATA_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_deser (
        .clk(clk), .rst_n(rst_n), .tick_i(sample_tick),
        .fall_i(fall), .bit_i(sbit),
        .byte_o(rbyte), .byte_valid_o(bvalid),
        .err_parity_o(err_parity), .err_stop_o(err_stop),
        .err_timeout_o(err_timeout)
    );

    ps2rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(bvalid), .wdata_i(rbyte),
        .pop_i(rd_en), .flush_i(rx_flush),
        .rdata_o(rd_data), .count_o(fill_count), .empty_o(empty),
        .overflow_o(rx_overflow)
    );

    assign rx_avail = !empty;
endmodule

// File: tb/test_ps2_frame_rx.sv
`timescale 1ns/1ps
module test_ps2_frame_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       ps2_clk_in = 1'b1;
    logic       ps2_data_in = 1'b1;
    logic       rx_flush = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] fill_count;
    logic       rx_avail, err_parity, err_stop, err_timeout, rx_overflow;

    int n_checks = 0, n_fails = 0;
    int n_par = 0, n_stop = 0, n_to = 0, n_ovf = 0;
    bit drain = 1'b0, pop_req = 1'b0, done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    ps2_frame_rx i_ps2_frame_rx (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .ps2_clk_in(ps2_clk_in), .ps2_data_in(ps2_data_in),
        .rx_flush(rx_flush), .rd_en(rd_en), .rd_data(rd_data),
        .fill_count(fill_count), .rx_avail(rx_avail),
        .err_parity(err_parity), .err_stop(err_stop),
        .err_timeout(err_timeout), .rx_overflow(rx_overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sample tick: one cycle in ten
    initial forever begin
        repeat (9) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    end

    // pulse counters
    initial forever begin
        @(negedge clk);
        if (err_parity)  n_par++;
        if (err_stop)    n_stop++;
        if (err_timeout) n_to++;
        if (rx_overflow) n_ovf++;
    end

    // scoreboard monitor: pops the store and compares with expected queue
    initial forever begin
        @(negedge clk);
        if (rd_en) rd_en = 1'b0;
        else if (pop_req) begin
            rd_en = 1'b1;
            pop_req = 1'b0;
        end else if (drain && rx_avail) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected byte", rd_data, -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R2/R6 byte order", rd_data, e);
            end
            rd_en = 1'b1;
        end
    end

    task automatic line_bit(input bit b);
        ps2_data_in = b;
        repeat (25) @(negedge clk);
        ps2_clk_in = 1'b0;
        repeat (50) @(negedge clk);
        ps2_clk_in = 1'b1;
        repeat (25) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par,
                              input bit stop_v, input bit store);
        if (store) exp_q.push_back(b);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(b[i]);
        line_bit((~^b) ^ bad_par);
        line_bit(stop_v);
        ps2_data_in = 1'b1;
        repeat (100) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fill_count == 0 && !rx_avail, "R1 reset fill", fill_count, 0);
        check(!err_parity && !err_stop && !err_timeout && !rx_overflow,
              "R1 reset pulses", 1, 0);

        // R2 / R6 several patterns
        drain = 1'b1;
        send_frame(8'hA5, 0, 1, 1);
        send_frame(8'h00, 0, 1, 1);
        send_frame(8'hFF, 0, 1, 1);
        send_frame(8'h3C, 0, 1, 1);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2 all bytes read", exp_q.size(), 0);
        check(n_to == 0, "R5 no timeout during frames", n_to, 0);

        // R3 parity fault
        drain = 1'b0;
        send_frame(8'h81, 1, 1, 0);
        check(n_par == 1, "R3 parity pulse", n_par, 1);
        check(fill_count == 0, "R3 not stored", fill_count, 0);

        // R4 stop fault
        send_frame(8'h42, 0, 0, 0);
        check(n_stop == 1, "R4 stop pulse", n_stop, 1);
        check(fill_count == 0, "R4 not stored", fill_count, 0);
        check(n_par == 1, "R4 parity stays clean", n_par, 1);

        // R5 stall after start and three data bits
        line_bit(1'b0);
        line_bit(1'b1);
        line_bit(1'b0);
        line_bit(1'b1);
        ps2_data_in = 1'b1;
        repeat (1300) @(negedge clk);
        check(n_to == 1, "R5 timeout pulse", n_to, 1);
        check(fill_count == 0, "R5 partial dropped", fill_count, 0);
        drain = 1'b1;
        send_frame(8'h96, 0, 1, 1);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5 recovery frame", exp_q.size(), 0);

        // R7 overflow
        drain = 1'b0;
        send_frame(8'h11, 0, 1, 1);
        send_frame(8'h22, 0, 1, 1);
        send_frame(8'h33, 0, 1, 1);
        check(fill_count == 3, "R6 fill reaches 3", fill_count, 3);
        send_frame(8'h44, 0, 1, 0);
        check(n_ovf == 1, "R7 overflow pulse", n_ovf, 1);
        check(fill_count == 3, "R7 fill held", fill_count, 3);
        drain = 1'b1;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && fill_count == 0, "R7 first three kept",
              exp_q.size(), 0);

        // R8 flush whole store
        drain = 1'b0;
        send_frame(8'h55, 0, 1, 0);
        send_frame(8'h66, 0, 1, 0);
        check(fill_count == 2, "R8 fill before flush", fill_count, 2);
        rx_flush = 1'b1;
        @(negedge clk);
        rx_flush = 1'b0;
        check(fill_count == 0, "R8 flush in one cycle", fill_count, 0);

        // R8 flush during a frame
        fork
            send_frame(8'h5A, 0, 1, 1);
            begin
                repeat (400) @(negedge clk);
                rx_flush = 1'b1;
                @(negedge clk);
                rx_flush = 1'b0;
            end
        join
        check(fill_count == 1, "R8 frame survives flush", fill_count, 1);
        drain = 1'b1;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8 flushed-frame byte", exp_q.size(), 0);

        // R9 pop on empty
        drain = 1'b0;
        pop_req = 1'b1;
        repeat (4) @(negedge clk);
        check(fill_count == 0, "R9 empty pop no effect", fill_count, 0);
        send_frame(8'hC3, 0, 1, 1);
        check(fill_count == 1, "R9 next byte counted", fill_count, 1);
        drain = 1'b1;
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9 next byte reads", exp_q.size(), 0);

        finish_run();
    end
endmodule